// File: doc/BRIEF.md
# Debug Cycle Counter and Breakpoint

This block is a 16-bit counter inside the on-chip debug unit of a small 8-bit CPU. A mode field sets one of four uses for the register. It can time how many system clocks the CPU runs between two halts. It can act as a timer that counts down and asks for a halt when it reaches zero. It can hold an address that stops the CPU when a fetch reaches that address. It can also be parked so that it holds its value.

The debug host writes the register while the CPU is halted. Once the CPU is released, the block follows the start and stop rules of the selected mode. A break request out of the block sets the debug-mode flag, which comes back in on `dbg_mode_i`. Leaving debug mode is seen as a falling edge of that flag.

Top module: `dbg_cnt_brk`

## Requirements
- R1: After synchronous reset, `count_o` reads 0000h and `brk_o` is low. The block behaves as though it is in debug mode until `dbg_mode_i` is first seen low.
- R2: In mode 00 (cycle count), the first clock edge with `dbg_mode_i` low after it was high loads 0000h. After that, every edge with `dbg_mode_i` low adds one.
- R3: In mode 00, the count saturates at FFFFh. It holds there and never wraps to 0000h.
- R4: In modes 00 and 01, the count holds its value on every edge while `dbg_mode_i` is high and no write is made.
- R5: In mode 01 (countdown), leaving debug mode does not clear the count. Every edge with `dbg_mode_i` low and a nonzero count subtracts one, starting with the first such edge.
- R6: In mode 01, the edge that takes the count from 0001h to 0000h also raises `brk_o` for exactly one cycle. The count then stays at 0000h. If the count is already 0000h when the CPU runs, no break is raised.
- R7: In mode 01, if `dbg_mode_i` is high on the edge that would have reached zero, the count holds its value and no break is raised.
- R8: In mode 10 (PC match), `brk_o` is high in the same cycle when `fetch_i` is high, `dbg_mode_i` is low and `pc_i` equals the count. The count is not changed while the CPU runs. Without a fetch strobe or with a different PC, `brk_o` stays low.
- R9: In mode 11 (off), the count holds its value while the CPU runs and no break is raised.
- R10: A write (`wr_en_i` high) while `dbg_mode_i` is high loads `wr_data_i`, which is visible after the next edge. The write takes priority over any mode action. A write while `dbg_mode_i` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_mode_i | input | 1 | High while the CPU is halted in debug mode |
| pc_i | input | 16 | CPU program counter |
| fetch_i | input | 1 | High for the one cycle in which an instruction fetch is made at `pc_i` |
| wr_en_i | input | 1 | Write strobe from the debug port |
| wr_data_i | input | 16 | Value to load on a write |
| mode_i | input | 2 | Selects the mode: 00 cycle count, 01 countdown, 10 PC match, 11 off |
| count_o | output | 16 | Current count value |
| brk_o | output | 1 | Break request that sets the debug-mode flag |

## Verification
Two events can fall on the same edge: the countdown reaching zero, and the CPU entering debug mode. The bench loads 0002h, releases the CPU for one edge, and then raises `dbg_mode_i` on the edge that would reach zero. It expects the count to stay at 0001h with no break pulse. A second pairing is a debug-port write made in a cycle where the CPU runs in PC-match mode. There the bench checks that the compare value is unchanged and that no break occurs.

// File: rtl/dcb_pkg.sv
package dcb_pkg;

    typedef enum logic [1:0] {
        MODE_CYC  = 2'b00,
        MODE_DOWN = 2'b01,
        MODE_PCM  = 2'b10,
        MODE_OFF  = 2'b11
    } dcb_mode_e;

    typedef struct packed {
        logic run;    // CPU executing (not in debug mode)
        logic leave;  // first running cycle after debug mode
        logic load;   // debug-port write accepted
    } dcb_ctl_t;

endpackage

// File: rtl/dcb_phase.sv
module dcb_phase
    import dcb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     dbg_mode,
    input  logic     wr_en,
    output dcb_ctl_t ctl
);
    logic dbg_q;

    always_ff @(posedge clk) begin
        if (rst) dbg_q <= 1'b1;
        else     dbg_q <= dbg_mode;
    end

    always_comb begin
        ctl.run   = ~dbg_mode;
        ctl.leave = dbg_q & ~dbg_mode;
        ctl.load  = dbg_mode & wr_en;
    end
endmodule

// File: rtl/dcb_next.sv
module dcb_next
    import dcb_pkg::*;
#(
    parameter int W = 16
) (
    input  dcb_ctl_t   ctl,
    input  dcb_mode_e  mode,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] nxt,
    output logic       reach_zero
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
    localparam logic [W-1:0] CNT_ONE = W'(1);

    always_comb begin
        nxt        = cnt;
        reach_zero = 1'b0;
        if (ctl.load) begin
            nxt = wdata;
        end else begin
            unique case (mode)
                MODE_CYC: begin
                    if (ctl.leave)                         nxt = '0;
                    else if (ctl.run && cnt != CNT_MAX)    nxt = cnt + CNT_ONE;
                end
                MODE_DOWN: begin
                    if (ctl.run && cnt != '0)              nxt = cnt - CNT_ONE;
                    reach_zero = ctl.run && (cnt == CNT_ONE);
                end
                default: nxt = cnt;
            endcase
        end
    end
endmodule

// File: rtl/dcb_pcmatch.sv
module dcb_pcmatch
    import dcb_pkg::*;
#(
    parameter int W = 16
) (
    input  dcb_ctl_t     ctl,
    input  dcb_mode_e    mode,
    input  logic         fetch,
    input  logic [W-1:0] pc,
    input  logic [W-1:0] cnt,
    output logic         hit
);
    always_comb hit = (mode == MODE_PCM) && ctl.run && fetch && (pc == cnt);
endmodule

// File: rtl/dbg_cnt_brk.sv
module dbg_cnt_brk
    import dcb_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         dbg_mode_i,
    input  logic [W-1:0] pc_i,
    input  logic         fetch_i,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_data_i,
    input  logic [1:0]   mode_i,
    output logic [W-1:0] count_o,
    output logic         brk_o
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    dcb_mode_e    mode;
    dcb_ctl_t     ctl;
    logic [W-1:0] cnt_q, cnt_d;
    logic         zero_d, zero_q, pc_hit;

    assign mode = dcb_mode_e'(mode_i);

    dcb_phase u_phase (
        .clk(clk), .rst(rst), .dbg_mode(dbg_mode_i), .wr_en(wr_en_i), .ctl(ctl)
    );

    dcb_next #(.W(W)) u_next (
        .ctl(ctl), .mode(mode), .cnt(cnt_q), .wdata(wr_data_i),
        .nxt(cnt_d), .reach_zero(zero_d)
    );

    dcb_pcmatch #(.W(W)) u_pcm (
        .ctl(ctl), .mode(mode), .fetch(fetch_i), .pc(pc_i), .cnt(cnt_q), .hit(pc_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            zero_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            zero_q <= zero_d;
        end
    end

    assign count_o = cnt_q;
    assign brk_o   = zero_q | pc_hit;

    // R2
    cyc_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CYC && ctl.leave) |=> (count_o == '0));

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CYC && !dbg_mode_i && !ctl.leave && count_o == CNT_MAX) |=> (count_o == CNT_MAX));

    // R4
    dbg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dbg_mode_i && !wr_en_i) |=> $stable(count_o));

    // R5
    down_step_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_DOWN && !dbg_mode_i && count_o != '0) |=> (count_o == $past(count_o) - W'(1)));

    // R6
    zero_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        zero_q |=> !zero_q);

    // R8
    pc_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_PCM && !fetch_i) |-> !brk_o || zero_q);

    // R10
    wr_load_chk: assert property (@(posedge clk) disable iff (rst)
        (dbg_mode_i && wr_en_i) |=> (count_o == $past(wr_data_i)));
endmodule

// File: tb/dbg_cnt_brk_test.sv
module dbg_cnt_brk_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        dbg;
    logic [15:0] pc;
    logic        fetch;
    logic        wr;
    logic [15:0] wdata;
    logic [1:0]  mode;
    logic [15:0] count;
    logic        brk;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    dbg_cnt_brk uut (
        .clk(clk), .rst(rst), .dbg_mode_i(dbg), .pc_i(pc), .fetch_i(fetch),
        .wr_en_i(wr), .wr_data_i(wdata), .mode_i(mode), .count_o(count), .brk_o(brk)
    );

    // {dbg, wr, wdata, mode, fetch, pc, exp_count, exp_brk}
    localparam int NV = 20;
    localparam logic [53:0] VEC [NV] = '{
        {1'b1,1'b1,16'h1234,2'd0,1'b0,16'h0000,16'h1234,1'b0}, // R10 load
        {1'b0,1'b0,16'h0000,2'd0,1'b0,16'h0000,16'h0000,1'b0}, // R2 clear on exit
        {1'b0,1'b0,16'h0000,2'd0,1'b0,16'h0000,16'h0001,1'b0}, // R2
        {1'b0,1'b0,16'h0000,2'd0,1'b0,16'h0000,16'h0002,1'b0}, // R2
        {1'b1,1'b0,16'h0000,2'd0,1'b0,16'h0000,16'h0002,1'b0}, // R4
        {1'b1,1'b0,16'h0000,2'd0,1'b0,16'h0000,16'h0002,1'b0}, // R4
        {1'b1,1'b1,16'h0003,2'd1,1'b0,16'h0000,16'h0003,1'b0}, // R10
        {1'b0,1'b0,16'h0000,2'd1,1'b0,16'h0000,16'h0002,1'b0}, // R5 no clear
        {1'b0,1'b0,16'h0000,2'd1,1'b0,16'h0000,16'h0001,1'b0}, // R5
        {1'b0,1'b0,16'h0000,2'd1,1'b0,16'h0000,16'h0000,1'b1}, // R6 pulse
        {1'b0,1'b0,16'h0000,2'd1,1'b0,16'h0000,16'h0000,1'b0}, // R6 single
        {1'b1,1'b0,16'h0000,2'd1,1'b0,16'h0000,16'h0000,1'b0}, // R4
        {1'b1,1'b1,16'h0040,2'd2,1'b0,16'h0000,16'h0040,1'b0}, // R10
        {1'b0,1'b0,16'h0000,2'd2,1'b1,16'h003F,16'h0040,1'b0}, // R8 mismatch
        {1'b0,1'b0,16'h0000,2'd2,1'b0,16'h0040,16'h0040,1'b0}, // R8 no fetch
        {1'b0,1'b0,16'h0000,2'd2,1'b1,16'h0040,16'h0040,1'b1}, // R8 hit
        {1'b0,1'b1,16'h0099,2'd2,1'b0,16'h0000,16'h0040,1'b0}, // R10 ignored
        {1'b1,1'b1,16'h0005,2'd3,1'b0,16'h0000,16'h0005,1'b0}, // R10
        {1'b0,1'b0,16'h0000,2'd3,1'b0,16'h0000,16'h0005,1'b0}, // R9
        {1'b0,1'b0,16'h0000,2'd3,1'b0,16'h0000,16'h0005,1'b0}  // R9
    };

    task automatic check(input string req, input logic [15:0] ec, input logic eb);
        n_chk++;
        if (count !== ec || brk !== eb) begin
            n_bad++;
            $display("FAIL %s: count=%h brk=%b expected count=%h brk=%b", req, count, brk, ec, eb);
        end
    endtask

    task automatic drive(input logic d, input logic w, input logic [15:0] wd,
                         input logic [1:0] m, input logic f, input logic [15:0] p);
        dbg = d; wr = w; wdata = wd; mode = m; fetch = f; pc = p;
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    initial begin
        #1500000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: count=%h brk=%b expected count=n/a brk=n/a", count, brk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        drive(1'b1, 1'b0, 16'h0, 2'd0, 1'b0, 16'h0);
        repeat (3) tick();
        rst = 1'b0;
        check("R1", 16'h0000, 1'b0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][53], VEC[i][52], VEC[i][51:36], VEC[i][35:34], VEC[i][33], VEC[i][32:17]);
            tick();
            check($sformatf("vec%0d", i), VEC[i][16:1], VEC[i][0]);
        end

        // R7: debug entry on the edge that would reach zero
        drive(1'b1, 1'b1, 16'h0002, 2'd1, 1'b0, 16'h0); tick();
        drive(1'b0, 1'b0, 16'h0000, 2'd1, 1'b0, 16'h0); tick();
        check("R5", 16'h0001, 1'b0);
        drive(1'b1, 1'b0, 16'h0000, 2'd1, 1'b0, 16'h0); tick();
        check("R7", 16'h0001, 1'b0);
        tick();
        check("R7", 16'h0001, 1'b0);

        // R6: countdown already at zero raises no break
        drive(1'b1, 1'b1, 16'h0000, 2'd1, 1'b0, 16'h0); tick();
        drive(1'b0, 1'b0, 16'h0000, 2'd1, 1'b0, 16'h0); tick();
        check("R6", 16'h0000, 1'b0);
        tick();
        check("R6", 16'h0000, 1'b0);

        // R8: PC match at address FFFFh, write while running ignored
        drive(1'b1, 1'b1, 16'hFFFF, 2'd2, 1'b0, 16'h0); tick();
        drive(1'b0, 1'b0, 16'h0000, 2'd2, 1'b1, 16'hFFFF); tick();
        check("R8", 16'hFFFF, 1'b1);

        // R3: saturation in cycle-count mode
        drive(1'b1, 1'b0, 16'h0000, 2'd0, 1'b0, 16'h0); tick();
        drive(1'b0, 1'b0, 16'h0000, 2'd0, 1'b0, 16'h0); tick();
        check("R2", 16'h0000, 1'b0);
        repeat (65534) tick();
        check("R3", 16'hFFFE, 1'b0);
        tick();
        check("R3", 16'hFFFF, 1'b0);
        repeat (3) tick();
        check("R3", 16'hFFFF, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule